// File: doc/BRIEF.md
# I2C Byte FIFO Pair with Threshold Flags

This block sits between a host register port and an I2C shift engine. It holds two byte-wide queues. The transmit queue is filled by the host and drained by the engine. The receive queue is filled by the engine and drained by the host. Each queue reports its fill level together with full and empty flags. The transmit side also raises a nearly-empty flag and the receive side a nearly-full flag. Each of these is set by comparing the level against a 4-bit threshold, so the largest threshold is 15.

A host write that meets a full transmit queue is discarded and sets a sticky overrun flag. Each queue has its own flush request. A one-cycle request starts a flush of fixed length. Its busy flag stays high for the whole flush and then clears without further action, which signals completion. While a flush is under way, strobes to that queue are ignored. Both queues are first-word fall-through: the head byte is presented on the read data port whenever the queue is not empty.

Top module: `i2c_fifo_pair`

## Requirements
- R1: After reset both levels are 0, both empty flags are 1, both full flags are 0, the overrun flag is 0, both flush busy flags are 0, and nearly-empty is 1.
- R2: Bytes written by the host into the transmit queue are presented on `eng_tx_data_o` in write order, one per engine pop. `tx_level_o` counts the entries held.
- R3: Bytes pushed by the engine into the receive queue are presented on `host_rx_data_o` in push order, one per host read. `rx_level_o` counts the entries held.
- R4: A queue holds at most 16 entries. Its full flag is 1 exactly at 16 and its empty flag is 1 exactly at 0. A push into a full queue leaves the level and the stored bytes unchanged.
- R5: A host write while the transmit queue is full sets `tx_ovr_o`. The flag stays set until a transmit flush is requested, and it reads 0 from the cycle after that request.
- R6: `tx_near_empty_o` is 1 exactly when `tx_level_o` is less than or equal to `tx_thresh_i` (0 to 15).
- R7: `rx_near_full_o` is 1 exactly when `rx_level_o` is greater than or equal to `rx_thresh_i` (0 to 15).
- R8: A flush request seen while that queue is idle raises its busy flag at the next edge. The flag stays high for FLUSH_CYCLES cycles (4 by default) and then clears by itself. The queue's level is 0 from the edge after the request.
- R9: While a queue's flush is requested or busy, pushes and pops on that queue are ignored. The other queue keeps working normally.
- R10: A pop from an empty queue is ignored. A push and a pop in the same cycle on a partly filled queue leave the level unchanged and keep the byte order.
- R11: A flush request that arrives while that queue is already busy does not lengthen the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_tx_wr_i | input | 1 | Host write strobe into the transmit queue |
| host_tx_data_i | input | 8 | Host write byte |
| host_rx_rd_i | input | 1 | Host read strobe from the receive queue |
| host_rx_data_o | output | 8 | Head byte of the receive queue |
| eng_tx_rd_i | input | 1 | Engine pop strobe from the transmit queue |
| eng_tx_data_o | output | 8 | Head byte of the transmit queue |
| eng_rx_wr_i | input | 1 | Engine push strobe into the receive queue |
| eng_rx_data_i | input | 8 | Engine push byte |
| tx_thresh_i | input | 4 | Transmit nearly-empty threshold |
| rx_thresh_i | input | 4 | Receive nearly-full threshold |
| tx_flush_req_i | input | 1 | Transmit flush request (write-1 pulse) |
| rx_flush_req_i | input | 1 | Receive flush request (write-1 pulse) |
| tx_flush_busy_o | output | 1 | Transmit flush in progress, clears by itself |
| rx_flush_busy_o | output | 1 | Receive flush in progress, clears by itself |
| tx_level_o | output | 5 | Transmit queue entry count |
| rx_level_o | output | 5 | Receive queue entry count |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_full_o | output | 1 | Transmit queue full |
| tx_near_empty_o | output | 1 | Transmit level at or below threshold |
| tx_ovr_o | output | 1 | Sticky transmit overrun |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_full_o | output | 1 | Receive queue full |
| rx_near_full_o | output | 1 | Receive level at or above threshold |

## Verification
The hardest case to reach is a flush that overlaps other traffic. In the middle of a transmit flush, the stimulus issues a host write, an engine pop and a second flush request to the transmit queue in one cycle, and in that same cycle pushes a byte into the receive queue. The bench then counts the busy cycles, confirms the transmit queue is still empty, and confirms the receive byte arrives. Both queues are also driven to full and pushed once more, so the dropped byte, the sticky overrun and its clearing by flush can all be observed at the ports.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  // direction of the level/threshold comparison
  typedef enum logic {CMP_AT_OR_BELOW = 1'b0, CMP_AT_OR_ABOVE = 1'b1} thr_cmp_e;
endpackage

// File: rtl/i2cf_flush_ctrl.sv
module i2cf_flush_ctrl #(
  parameter int unsigned FLUSH_CYCLES = 4,
  localparam int unsigned CW = (FLUSH_CYCLES > 1) ? $clog2(FLUSH_CYCLES) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic start_o,
  output logic clr_o,
  output logic busy_o
);
  localparam logic [CW-1:0] LAST = CW'(FLUSH_CYCLES - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign start_o = req_i & ~busy_q;
  assign clr_o   = start_o | busy_q;
  assign busy_o  = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) busy_q <= 1'b0;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  p_req_starts_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !busy_o |=> busy_o);
  p_busy_holds_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && (cnt_q != LAST) |=> busy_o);
  p_busy_ends_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && (cnt_q == LAST) |=> !busy_o);
endmodule

// File: rtl/i2cf_byte_fifo.sv
module i2cf_byte_fifo import i2cf_pkg::*; #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned THR_W = 4,
  parameter thr_cmp_e    CMP   = CMP_AT_OR_BELOW,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned LW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  byte_t         push_data_i,
  input  logic          pop_i,
  output byte_t         head_o,
  input  logic [THR_W-1:0] thresh_i,
  output logic [LW-1:0] level_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          thr_hit_o,
  output logic          drop_o
);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  byte_t         mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [LW-1:0] count_q;
  logic          do_push, do_pop;
  logic [LW-1:0] thr_ext;

  assign full_o  = (count_q == FULL_LVL);
  assign empty_o = (count_q == '0);
  assign do_push = push_i & ~clr_i & ~full_o;
  assign do_pop  = pop_i & ~clr_i & ~empty_o;
  assign drop_o  = push_i & ~clr_i & full_o;
  assign head_o  = mem[rd_ptr_q];
  assign level_o = count_q;
  assign thr_ext = LW'(thresh_i);

  generate
    if (CMP == CMP_AT_OR_BELOW) begin : g_below
      assign thr_hit_o = (count_q <= thr_ext);
    end else begin : g_above
      assign thr_hit_o = (count_q >= thr_ext);
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
      unique case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  p_level_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= FULL_LVL);
  p_full_stays_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i && !clr_i |=> full_o);
  p_empty_pop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && pop_i && !push_i && !clr_i |=> empty_o);
  p_clr_empties_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> level_o == '0);
  p_pushpop_level_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && pop_i && !clr_i && !empty_o && !full_o |=> $stable(level_o));
endmodule

// File: rtl/i2c_fifo_pair.sv
module i2c_fifo_pair import i2cf_pkg::*; #(
  parameter int unsigned DEPTH        = 16,
  parameter int unsigned THR_W        = 4,
  parameter int unsigned FLUSH_CYCLES = 4,
  localparam int unsigned LW = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_tx_wr_i,
  input  logic [7:0]       host_tx_data_i,
  input  logic             host_rx_rd_i,
  output logic [7:0]       host_rx_data_o,
  input  logic             eng_tx_rd_i,
  output logic [7:0]       eng_tx_data_o,
  input  logic             eng_rx_wr_i,
  input  logic [7:0]       eng_rx_data_i,
  input  logic [THR_W-1:0] tx_thresh_i,
  input  logic [THR_W-1:0] rx_thresh_i,
  input  logic             tx_flush_req_i,
  input  logic             rx_flush_req_i,
  output logic             tx_flush_busy_o,
  output logic             rx_flush_busy_o,
  output logic [LW-1:0]    tx_level_o,
  output logic [LW-1:0]    rx_level_o,
  output logic             tx_empty_o,
  output logic             tx_full_o,
  output logic             tx_near_empty_o,
  output logic             tx_ovr_o,
  output logic             rx_empty_o,
  output logic             rx_full_o,
  output logic             rx_near_full_o
);
  logic tx_start, tx_clr, rx_start, rx_clr;
  logic tx_drop, rx_drop;
  logic ovr_q;

  i2cf_flush_ctrl #(.FLUSH_CYCLES(FLUSH_CYCLES)) u_tx_flush (
    .clk_i, .rst_ni, .req_i(tx_flush_req_i),
    .start_o(tx_start), .clr_o(tx_clr), .busy_o(tx_flush_busy_o));

  i2cf_flush_ctrl #(.FLUSH_CYCLES(FLUSH_CYCLES)) u_rx_flush (
    .clk_i, .rst_ni, .req_i(rx_flush_req_i),
    .start_o(rx_start), .clr_o(rx_clr), .busy_o(rx_flush_busy_o));

  i2cf_byte_fifo #(.DEPTH(DEPTH), .THR_W(THR_W), .CMP(CMP_AT_OR_BELOW)) u_tx_fifo (
    .clk_i, .rst_ni, .clr_i(tx_clr),
    .push_i(host_tx_wr_i), .push_data_i(host_tx_data_i),
    .pop_i(eng_tx_rd_i), .head_o(eng_tx_data_o),
    .thresh_i(tx_thresh_i), .level_o(tx_level_o),
    .empty_o(tx_empty_o), .full_o(tx_full_o),
    .thr_hit_o(tx_near_empty_o), .drop_o(tx_drop));

  i2cf_byte_fifo #(.DEPTH(DEPTH), .THR_W(THR_W), .CMP(CMP_AT_OR_ABOVE)) u_rx_fifo (
    .clk_i, .rst_ni, .clr_i(rx_clr),
    .push_i(eng_rx_wr_i), .push_data_i(eng_rx_data_i),
    .pop_i(host_rx_rd_i), .head_o(host_rx_data_o),
    .thresh_i(rx_thresh_i), .level_o(rx_level_o),
    .empty_o(rx_empty_o), .full_o(rx_full_o),
    .thr_hit_o(rx_near_full_o), .drop_o(rx_drop));

  // sticky overrun, cleared when a transmit flush begins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ovr_q <= 1'b0;
    else if (tx_start) ovr_q <= 1'b0;
    else if (tx_drop)  ovr_q <= 1'b1;
  end
  assign tx_ovr_o = ovr_q;

  p_ovr_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_tx_wr_i && tx_full_o && !tx_flush_req_i && !tx_flush_busy_o |=> tx_ovr_o);
  p_ovr_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_flush_req_i && !tx_flush_busy_o |=> !tx_ovr_o);
  p_tx_flush_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_flush_busy_o |-> tx_level_o == '0);
  p_rx_flush_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_flush_busy_o |-> rx_level_o == '0);
  p_rx_no_ovr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_drop |=> rx_full_o);
endmodule

// File: tb/i2c_fifo_pair_bench.sv
module i2c_fifo_pair_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic host_tx_wr = 0, host_rx_rd = 0, eng_tx_rd = 0, eng_rx_wr = 0;
  logic [7:0] host_tx_data = 0, eng_rx_data = 0;
  logic [7:0] host_rx_data, eng_tx_data;
  logic [3:0] tx_thr = 4'd2, rx_thr = 4'd3;
  logic tx_freq = 0, rx_freq = 0;
  logic tx_busy, rx_busy, tx_empty, tx_full, tx_ne, tx_ovr, rx_empty, rx_full, rx_nf;
  logic [4:0] tx_lvl, rx_lvl;

  i2c_fifo_pair u_i2c_fifo_pair (
    .clk_i(clk), .rst_ni(rst_n),
    .host_tx_wr_i(host_tx_wr), .host_tx_data_i(host_tx_data),
    .host_rx_rd_i(host_rx_rd), .host_rx_data_o(host_rx_data),
    .eng_tx_rd_i(eng_tx_rd), .eng_tx_data_o(eng_tx_data),
    .eng_rx_wr_i(eng_rx_wr), .eng_rx_data_i(eng_rx_data),
    .tx_thresh_i(tx_thr), .rx_thresh_i(rx_thr),
    .tx_flush_req_i(tx_freq), .rx_flush_req_i(rx_freq),
    .tx_flush_busy_o(tx_busy), .rx_flush_busy_o(rx_busy),
    .tx_level_o(tx_lvl), .rx_level_o(rx_lvl),
    .tx_empty_o(tx_empty), .tx_full_o(tx_full), .tx_near_empty_o(tx_ne),
    .tx_ovr_o(tx_ovr), .rx_empty_o(rx_empty), .rx_full_o(rx_full),
    .rx_near_full_o(rx_nf));

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver: host write, expected byte queued when there is room
  task automatic host_wr(logic [7:0] b);
    host_tx_wr = 1; host_tx_data = b;
    @(negedge clk);
    host_tx_wr = 0;
    if (tx_q.size() < 16) tx_q.push_back(b);
  endtask

  task automatic eng_wr(logic [7:0] b);
    eng_rx_wr = 1; eng_rx_data = b;
    @(negedge clk);
    eng_rx_wr = 0;
    if (rx_q.size() < 16) rx_q.push_back(b);
  endtask

  // monitor side: head byte compared against scoreboard before the pop
  task automatic eng_rd(string tag);
    if (tx_q.size() > 0) chk(tag, eng_tx_data, tx_q.pop_front());
    eng_tx_rd = 1;
    @(negedge clk);
    eng_tx_rd = 0;
  endtask

  task automatic host_rd(string tag);
    if (rx_q.size() > 0) chk(tag, host_rx_data, rx_q.pop_front());
    host_rx_rd = 1;
    @(negedge clk);
    host_rx_rd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int busy_n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 tx_level", tx_lvl, 0);
    chk("R1 rx_level", rx_lvl, 0);
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 rx_empty", rx_empty, 1);
    chk("R1 fulls", {tx_full, rx_full}, 0);
    chk("R1 ovr", tx_ovr, 0);
    chk("R1 busy", {tx_busy, rx_busy}, 0);
    chk("R1 near_empty", tx_ne, 1);

    // R2 / R6: threshold 2
    host_wr(8'h11); host_wr(8'h22);
    chk("R6 level2 near_empty", tx_ne, 1);
    host_wr(8'h33);
    chk("R6 level3 not near_empty", tx_ne, 0);
    chk("R2 tx_level", tx_lvl, 3);
    host_wr(8'h44); host_wr(8'h55);
    chk("R2 tx_level5", tx_lvl, 5);
    // R10 simultaneous push and pop
    chk("R10 head before", eng_tx_data, tx_q[0]);
    void'(tx_q.pop_front());
    tx_q.push_back(8'h66);
    host_tx_wr = 1; host_tx_data = 8'h66; eng_tx_rd = 1;
    @(negedge clk);
    host_tx_wr = 0; eng_tx_rd = 0;
    chk("R10 level kept", tx_lvl, 5);
    for (int i = 0; i < 5; i++) eng_rd("R2 tx order");
    chk("R2 drained", tx_empty, 1);
    eng_rd("R10 pop empty");
    chk("R10 pop empty level", tx_lvl, 0);
    chk("R10 pop empty flag", tx_empty, 1);

    // R3 / R7: threshold 3
    eng_wr(8'hA1); eng_wr(8'hA2);
    chk("R7 level2 not near_full", rx_nf, 0);
    eng_wr(8'hA3);
    chk("R7 level3 near_full", rx_nf, 1);
    eng_wr(8'hA4);
    chk("R3 rx_level", rx_lvl, 4);
    for (int i = 0; i < 4; i++) host_rd("R3 rx order");
    chk("R3 rx_empty", rx_empty, 1);

    // R4 / R5 / R6 at threshold 15
    tx_thr = 4'd15;
    for (int i = 0; i < 15; i++) host_wr(8'(8'h80 + i));
    chk("R6 level15 near_empty", tx_ne, 1);
    chk("R4 not full at 15", tx_full, 0);
    host_wr(8'h8F);
    chk("R6 level16 not near_empty", tx_ne, 0);
    chk("R4 full", tx_full, 1);
    chk("R5 no ovr yet", tx_ovr, 0);
    host_wr(8'hEE);
    chk("R4 level held", tx_lvl, 16);
    chk("R5 ovr set", tx_ovr, 1);
    for (int i = 0; i < 16; i++) eng_rd("R4 data after drop");
    chk("R4 empty", tx_empty, 1);
    chk("R5 ovr sticky", tx_ovr, 1);

    // R8 / R9 / R11 transmit flush
    tx_thr = 4'd2;
    host_wr(8'h01); host_wr(8'h02); host_wr(8'h03);
    tx_freq = 1;
    @(negedge clk);
    tx_freq = 0;
    tx_q.delete();
    busy_n = 0;
    chk("R8 busy raised", tx_busy, 1);
    chk("R8 level cleared", tx_lvl, 0);
    chk("R5 ovr cleared", tx_ovr, 0);
    if (tx_busy) busy_n++;
    host_tx_wr = 1; host_tx_data = 8'h77; eng_tx_rd = 1; tx_freq = 1;
    eng_rx_wr = 1; eng_rx_data = 8'hA5;
    @(negedge clk);
    host_tx_wr = 0; eng_tx_rd = 0; tx_freq = 0; eng_rx_wr = 0;
    rx_q.push_back(8'hA5);
    chk("R9 tx write ignored", tx_lvl, 0);
    chk("R9 rx unaffected", rx_lvl, 1);
    for (int i = 0; i < 8; i++) begin
      if (tx_busy) busy_n++;
      @(negedge clk);
    end
    chk("R8 R11 busy length", busy_n, 4);
    chk("R8 self clear", tx_busy, 0);
    chk("R9 tx empty after", tx_empty, 1);
    host_rd("R9 rx byte during flush");
    host_wr(8'h5A);
    chk("R8 accepts after flush", tx_lvl, 1);
    eng_rd("R2 after flush");

    // R4 / R8 / R9 receive side
    for (int i = 0; i < 17; i++) eng_wr(8'(8'hC0 + i));
    chk("R4 rx full", rx_full, 1);
    chk("R4 rx level held", rx_lvl, 16);
    host_rd("R4 rx first"); host_rd("R4 rx second");
    chk("R3 rx level14", rx_lvl, 14);
    rx_freq = 1;
    @(negedge clk);
    rx_freq = 0;
    rx_q.delete();
    chk("R8 rx busy", rx_busy, 1);
    host_rx_rd = 1; eng_rx_wr = 1; eng_rx_data = 8'h99;
    @(negedge clk);
    host_rx_rd = 0; eng_rx_wr = 0;
    chk("R9 rx access ignored", rx_lvl, 0);
    repeat (6) @(negedge clk);
    chk("R8 rx self clear", rx_busy, 0);
    chk("R8 rx empty", rx_empty, 1);
    chk("R9 tx untouched", tx_lvl, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule